// File: doc/BRIEF.md
# Width-Configurable Dual-Clock FIFO Controller

This block is a first-in first-out buffer whose writer and reader run on unrelated clocks. It sits around a single storage array of 128 rows by 36 bits. A 3-bit shape code divides that array into one of six word-width and depth pairs. The same width applies on both sides, so each word comes out exactly as it went in. Each port clock has its own polarity select, which lets either side act on the falling edge instead of the rising one.

Each side keeps a binary pointer one bit wider than the deepest shape needs. The pointer is carried to the other domain in Gray code through two flops, and each side derives its flags from its own pointer and the synchronized copy of the other pointer. The full and almost-full flags belong to the write side. The empty and almost-empty flags belong to the read side. The two "almost" limits are 8-bit fractions of the selected depth, in 256ths. An optional second register on the read path adds one cycle of latency. An active-high clear, asynchronous in both domains, empties the FIFO. The shape code must be held stable while the FIFO is out of clear.

Top module: `wc_fifo_ctrl`

## Requirements
- R1: While `clr` is high, `empty` and `aempty` read 1, `full` and `afull` read 0, and `rd_data` reads 0. This applies asynchronously and leaves both pointers at zero.
- R2: Words are read in the order they were written. The shape code sets width and depth: 000 gives 1 bit x 4096, 001 gives 2 x 2048, 010 gives 4 x 1024, 011 gives 9 x 512, 100 gives 18 x 256, and 101 gives 36 x 128. Only the low `width` bits of `wr_data` are stored, and `rd_data` bits above `width` read 0.
- R3: A write attempted while `full` is high changes nothing. No word is stored and no stored word is overwritten.
- R4: A read attempted while `empty` is high changes nothing. The read pointer stays put and `rd_data` holds its value.
- R5: For every shape, `full` rises once exactly `depth` words are held, and not before.
- R6: `aempty` is 1 when the read-side occupancy is at most floor(`ae_thr` * depth / 256).
- R7: `afull` is 1 when the write-side free space (depth minus occupancy) is at most floor(`af_thr` * depth / 256).
- R8: With `rd_pipe` = 0, the word popped at a read edge is on `rd_data` right after that edge. With `rd_pipe` = 1, it appears one read edge later, and until then `rd_data` still shows the previous value.
- R9: With `wclk_inv` = 1, writes take effect on the falling edge of `wclk`. With `rclk_inv` = 1, reads take effect on the falling edge of `rclk`.
- R10: Shape codes 110 and 111 hold the FIFO in the clear state of R1, with the 36 x 128 geometry. Writes made under them are not stored.
- R11: Each pointer crosses domains in Gray code through two flops of the receiving clock, changing one bit per increment. A written word makes `empty` fall within four read edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wclk_inv | input | 1 | 1 selects the falling edge of `wclk` as active |
| rclk | input | 1 | Read-side clock |
| rclk_inv | input | 1 | 1 selects the falling edge of `rclk` as active |
| clr | input | 1 | Active-high asynchronous clear |
| wcode | input | 3 | Shape code (width and depth) |
| ae_thr | input | 8 | Almost-empty limit in 256ths of depth |
| af_thr | input | 8 | Almost-full limit in 256ths of depth |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word, low `width` bits used |
| rd_en | input | 1 | Read request |
| rd_pipe | input | 1 | 1 adds an output register on the read path |
| rd_data | output | 36 | Read word |
| full | output | 1 | FIFO holds `depth` words |
| afull | output | 1 | Free space at or below the almost-full limit |
| empty | output | 1 | No word visible to the reader |
| aempty | output | 1 | Occupancy at or below the almost-empty limit |

## Verification
The hardest situation to reach is the exact full boundary of the deepest shapes. Getting there takes thousands of writes, and the flags must be judged only after the pointers have crossed the two-flop synchronizers. The bench fills each shape to one word short of depth and then to depth, letting both domains settle before it samples. For the 36 x 128 shape it walks the occupancy one word at a time, so both almost-flag limits are checked on either side. Polarity is exercised with enable pulses that span only the active half-period, so a port acting on the wrong edge misses the request entirely.

// File: rtl/wc_fifo_pkg.sv
package wc_fifo_pkg;

    localparam int unsigned WC_DATA_W = 36;
    localparam int unsigned WC_ADDR_W = 12;
    localparam int unsigned WC_ROW_LG = 7;

    // log2 of depth for a shape code; reserved codes take the 36-wide geometry
    function automatic logic [3:0] wc_depth_lg(input logic [2:0] code);
        logic [3:0] lg;
        case (code)
            3'd0:    lg = 4'd12;
            3'd1:    lg = 4'd11;
            3'd2:    lg = 4'd10;
            3'd3:    lg = 4'd9;
            3'd4:    lg = 4'd8;
            default: lg = 4'd7;
        endcase
        return lg;
    endfunction

    function automatic logic [5:0] wc_word_w(input logic [2:0] code);
        logic [5:0] w;
        case (code)
            3'd0:    w = 6'd1;
            3'd1:    w = 6'd2;
            3'd2:    w = 6'd4;
            3'd3:    w = 6'd9;
            3'd4:    w = 6'd18;
            default: w = 6'd36;
        endcase
        return w;
    endfunction

    function automatic logic wc_is_reserved(input logic [2:0] code);
        return code[2] & code[1];
    endfunction

endpackage

// File: rtl/wc_sync2.sv
module wc_sync2 #(
    parameter int unsigned PW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1_q;
    logic [PW-1:0] stage2_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        for (int i = 0; i < int'(PW); i++) begin
            bin_out[i] = ^(stage2_q >> i);
        end
    end
endmodule

// File: rtl/wc_store.sv
module wc_store #(
    parameter int unsigned ROW_W  = 36,
    parameter int unsigned ROW_LG = 7,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ROW_W-1:0]  wdata,
    input  logic [3:0]        depth_lg,
    input  logic [5:0]        word_w,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ROW_W-1:0]  rdata
);
    localparam int unsigned ROWS  = 1 << ROW_LG;
    localparam int unsigned LANEW = ADDR_W - ROW_LG;

    logic [ROW_W-1:0]  mem [ROWS];
    logic [3:0]        lane_sh;
    logic [LANEW-1:0]  lane_mask;
    logic [ROW_LG-1:0] wrow, rrow;
    logic [5:0]        woff, roff;
    logic [ROW_W-1:0]  wmask;

    always_comb begin
        lane_sh   = depth_lg - 4'(ROW_LG);
        lane_mask = LANEW'((32'd1 << lane_sh) - 32'd1);
        wrow      = ROW_LG'(waddr >> lane_sh);
        rrow      = ROW_LG'(raddr >> lane_sh);
        woff      = 6'(int'(waddr[LANEW-1:0] & lane_mask) * int'(word_w));
        roff      = 6'(int'(raddr[LANEW-1:0] & lane_mask) * int'(word_w));
        wmask     = (ROW_W'(1) << word_w) - ROW_W'(1);
        rdata     = (mem[rrow] >> roff) & wmask;
    end

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[wrow] <= (mem[wrow] & ~(wmask << woff)) | ((wdata & wmask) << woff);
        end
    end
endmodule

// File: rtl/wc_fifo_ctrl.sv
module wc_fifo_ctrl
    import wc_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = WC_DATA_W,
    parameter int unsigned ADDR_W = WC_ADDR_W,
    parameter int unsigned ROW_LG = WC_ROW_LG,
    parameter int unsigned THR_W  = 8
) (
    input  logic              wclk,
    input  logic              wclk_inv,
    input  logic              rclk,
    input  logic              rclk_inv,
    input  logic              clr,
    input  logic [2:0]        wcode,
    input  logic [THR_W-1:0]  ae_thr,
    input  logic [THR_W-1:0]  af_thr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_pipe,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              afull,
    output logic              empty,
    output logic              aempty
);
    localparam int unsigned PW = ADDR_W + 1;
    localparam int unsigned SW = PW + THR_W;

    logic             wclk_e, rclk_e, clr_any;
    logic [3:0]       depth_lg;
    logic [5:0]       word_w;
    logic [PW-1:0]    depth;
    logic [PW-1:0]    ae_lim, af_lim;

    assign wclk_e   = wclk ^ wclk_inv;
    assign rclk_e   = rclk ^ rclk_inv;
    assign clr_any  = clr | wc_is_reserved(wcode);
    assign depth_lg = wc_depth_lg(wcode);
    assign word_w   = wc_word_w(wcode);
    assign depth    = PW'(1) << depth_lg;
    assign ae_lim   = PW'((SW'(ae_thr) << depth_lg) >> THR_W);
    assign af_lim   = PW'((SW'(af_thr) << depth_lg) >> THR_W);

    // ---------------- write domain ----------------
    logic [PW-1:0] wbin, wgray, wbin_nx, rsync_bin, occ_w;
    logic          wr_fire;

    assign occ_w   = wbin - rsync_bin;
    assign full    = (occ_w == depth);
    assign afull   = ((depth - occ_w) <= af_lim);
    assign wr_fire = wr_en & ~full;
    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge wclk_e or posedge clr_any) begin
        if (clr_any) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_fire) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // ---------------- read domain ----------------
    logic [PW-1:0]     rbin, rgray, rbin_nx, wsync_bin, occ_r;
    logic              rd_fire;
    logic [DATA_W-1:0] mem_q, rd_q, rd_p;

    assign occ_r   = wsync_bin - rbin;
    assign empty   = (occ_r == '0);
    assign aempty  = (occ_r <= ae_lim);
    assign rd_fire = rd_en & ~empty;
    assign rbin_nx = rbin + PW'(1);
    assign rd_data = rd_pipe ? rd_p : rd_q;

    always_ff @(posedge rclk_e or posedge clr_any) begin
        if (clr_any) begin
            rbin  <= '0;
            rgray <= '0;
            rd_q  <= '0;
            rd_p  <= '0;
        end else begin
            rd_p <= rd_q;
            if (rd_fire) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
                rd_q  <= mem_q;
            end
        end
    end

    // ---------------- crossings and storage ----------------
    wc_sync2 #(.PW(PW)) wsync_i (
        .clk(rclk_e), .rst(clr_any), .gray_in(wgray), .bin_out(wsync_bin)
    );

    wc_sync2 #(.PW(PW)) rsync_i (
        .clk(wclk_e), .rst(clr_any), .gray_in(rgray), .bin_out(rsync_bin)
    );

    wc_store #(.ROW_W(DATA_W), .ROW_LG(ROW_LG), .ADDR_W(ADDR_W)) store_i (
        .wclk(wclk_e), .we(wr_fire), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
        .depth_lg(depth_lg), .word_w(word_w), .raddr(rbin[ADDR_W-1:0]), .rdata(mem_q)
    );

    // ---------------- assertions ----------------
    p_clear_state_r1: assert property (@(posedge rclk_e)
        clr_any |-> (empty && aempty && !full && !afull && rd_data == '0));

    p_no_overflow_r3: assert property (@(posedge wclk_e) disable iff (clr_any)
        (full && wr_en) |=> $stable(wbin));

    p_occ_bound_w_r5: assert property (@(posedge wclk_e) disable iff (clr_any)
        occ_w <= depth);

    p_no_underflow_r4: assert property (@(posedge rclk_e) disable iff (clr_any)
        (empty && rd_en) |=> ($stable(rbin) && $stable(rd_q)));

    p_occ_bound_r_r2: assert property (@(posedge rclk_e) disable iff (clr_any)
        occ_r <= depth);

    p_wgray_step_r11: assert property (@(posedge wclk_e) disable iff (clr_any)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_rgray_step_r11: assert property (@(posedge rclk_e) disable iff (clr_any)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/wc_fifo_ctrl_tb.sv
module wc_fifo_ctrl_tb_top;
    localparam int W_PERIOD = 10;
    localparam int R_PERIOD = 14;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        wclk_inv = 1'b0, rclk_inv = 1'b0;
    logic        clr = 1'b1;
    logic [2:0]  wcode = 3'd5;
    logic [7:0]  ae_thr = 8'd64, af_thr = 8'd32;
    logic        wr_en = 1'b0, rd_en = 1'b0, rd_pipe = 1'b0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        full, afull, empty, aempty;
    logic        wact, ract;

    int nchk = 0;
    int nbad = 0;

    always #(W_PERIOD/2) wclk = ~wclk;
    always #(R_PERIOD/2) rclk = ~rclk;
    assign wact = wclk ^ wclk_inv;
    assign ract = rclk ^ rclk_inv;

    wc_fifo_ctrl dut_i (
        .wclk(wclk), .wclk_inv(wclk_inv), .rclk(rclk), .rclk_inv(rclk_inv),
        .clr(clr), .wcode(wcode), .ae_thr(ae_thr), .af_thr(af_thr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_pipe(rd_pipe),
        .rd_data(rd_data), .full(full), .afull(afull), .empty(empty), .aempty(aempty)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] word_of(input int i);
        logic [35:0] p;
        p = 36'(i) * 36'h09E3779B1;
        return p ^ 36'h5A5A5A5A5;
    endfunction

    function automatic logic [35:0] wmask(input int w);
        return (w >= 36) ? {36{1'b1}} : ((36'd1 << w) - 36'd1);
    endfunction

    // enable held only across the half-period that contains the active edge
    task automatic push(input logic [35:0] d);
        @(negedge wact); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge wact); #1;
        wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge ract); #1;
        rd_en = 1'b1;
        @(posedge ract); #1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge ract);
        repeat (4) @(posedge wact);
        #1;
    endtask

    task automatic restart(input logic [2:0] c);
        clr = 1'b1;
        wcode = c;
        repeat (2) @(posedge wclk);
        #1;
        clr = 1'b0;
        settle();
    endtask

    task automatic flags_clear(input string req);
        chk(empty == 1'b1, {req, " empty"}, 36'(empty), 36'd1);
        chk(aempty == 1'b1, {req, " aempty"}, 36'(aempty), 36'd1);
        chk(full == 1'b0, {req, " full"}, 36'(full), 36'd0);
        chk(afull == 1'b0, {req, " afull"}, 36'(afull), 36'd0);
        chk(rd_data == '0, {req, " rd_data"}, rd_data, 36'd0);
    endtask

    initial begin
        repeat (190000) @(posedge wclk);
        nbad++;
        $display("FAIL watchdog (all requirements) actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        int depth, w, ae_lim, af_lim;
        logic [35:0] exp;

        // R1: reset state
        repeat (3) @(posedge wclk);
        #1;
        flags_clear("R1");
        clr = 1'b0;
        settle();

        // 36 x 128: occupancy walk across both almost limits
        depth = 128;
        ae_lim = (64 * depth) / 256;
        af_lim = (32 * depth) / 256;
        for (int k = 1; k <= depth; k++) begin
            push(word_of(k));
            settle();
            chk(empty == 1'b0, "R11 empty after write", 36'(empty), 36'd0);
            chk(full == (k == depth), "R5 full at depth", 36'(full), 36'(k == depth));
            chk(aempty == (k <= ae_lim), "R6 aempty limit", 36'(aempty), 36'(k <= ae_lim));
            chk(afull == ((depth - k) <= af_lim), "R7 afull limit", 36'(afull), 36'((depth - k) <= af_lim));
        end
        push(36'hFFFF0000F);
        settle();
        chk(full == 1'b1, "R3 full after ignored write", 36'(full), 36'd1);
        for (int k = 1; k <= depth; k++) begin
            pop();
            chk(rd_data == word_of(k), "R2 order 36x128", rd_data, word_of(k));
        end
        settle();
        chk(empty == 1'b1, "R3 extra word not stored", 36'(empty), 36'd1);
        pop();
        chk(rd_data == word_of(depth), "R4 read on empty holds data", rd_data, word_of(depth));
        settle();
        chk(empty == 1'b1, "R4 still empty", 36'(empty), 36'd1);

        // remaining shapes: full boundary and width masking
        for (int c = 0; c < 5; c++) begin
            restart(3'(c));
            depth = 4096 >> c;
            w = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 9 : 18;
            for (int k = 0; k < depth - 1; k++) push(word_of(k + 7 * c));
            settle();
            chk(full == 1'b0, "R5 not full at depth-1", 36'(full), 36'd0);
            push(word_of(depth - 1 + 7 * c));
            settle();
            chk(full == 1'b1, "R5 full at depth", 36'(full), 36'd1);
            for (int k = 0; k < depth; k++) begin
                pop();
                exp = word_of(k + 7 * c) & wmask(w);
                chk(rd_data == exp, "R2 order and width", rd_data, exp);
            end
            settle();
            chk(empty == 1'b1, "R2 drained", 36'(empty), 36'd1);
        end

        // R1: clear in the middle of operation
        restart(3'd3);
        for (int k = 0; k < 5; k++) push(word_of(k));
        settle();
        pop();
        clr = 1'b1;
        #2;
        flags_clear("R1 mid-run clear");
        #5;
        clr = 1'b0;
        settle();

        // R8: output pipeline
        rd_pipe = 1'b1;
        for (int k = 0; k < 3; k++) push(word_of(k + 50));
        settle();
        pop();
        chk(rd_data == '0, "R8 pipe not yet", rd_data, 36'd0);
        @(posedge ract); #1;
        exp = word_of(50) & wmask(9);
        chk(rd_data == exp, "R8 pipe one edge later", rd_data, exp);
        pop();
        chk(rd_data == exp, "R8 pipe holds previous", rd_data, exp);
        @(posedge ract); #1;
        exp = word_of(51) & wmask(9);
        chk(rd_data == exp, "R8 pipe second word", rd_data, exp);
        rd_pipe = 1'b0;

        // R9: falling-edge operation on both ports
        clr = 1'b1;
        wclk_inv = 1'b1;
        rclk_inv = 1'b1;
        restart(3'd5);
        for (int k = 0; k < 4; k++) push(word_of(k + 90));
        settle();
        chk(empty == 1'b0, "R9 falling-edge writes", 36'(empty), 36'd0);
        for (int k = 0; k < 4; k++) begin
            pop();
            chk(rd_data == word_of(k + 90), "R9 falling-edge reads", rd_data, word_of(k + 90));
        end
        settle();
        chk(empty == 1'b1, "R9 drained", 36'(empty), 36'd1);
        clr = 1'b1;
        wclk_inv = 1'b0;
        rclk_inv = 1'b0;

        // R10: reserved codes hold the clear state
        for (int c = 6; c < 8; c++) begin
            restart(3'(c));
            for (int k = 0; k < 3; k++) push(word_of(k + 200));
            settle();
            pop();
            flags_clear("R10 reserved code");
        end
        clr = 1'b1;
        wcode = 3'd5;
        #3;
        clr = 1'b0;
        settle();
        chk(empty == 1'b1, "R10 writes not stored", 36'(empty), 36'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule